// File: doc/BRIEF.md
# Byte-Oriented SPI Master with Register Control

This block is a serial peripheral interface master driven through a small word-addressed register bank. Software programs a configuration word (clock divider, bit order, clock and select polarity, clock phase, stream hold, enable, interrupt enable). It loads the byte to send and then writes a control word that carries a bit count and a start flag. The block then produces a divided serial clock and moves the outgoing bits onto MOSI while it captures MISO. When the last bit has been exchanged it latches the received bits, raises a done status and, if enabled, a level interrupt.

The select line is driven automatically around each transfer by default. In stream mode it stays asserted between transfers until software clears the stream bit. A manual override lets software hold the select line asserted or released directly.

The control engine is a four-state machine. ST_IDLE waits for an accepted start and goes to ST_LOW. ST_LOW holds the serial clock at its idle level for one half period and goes to ST_HIGH on the timer tick, which makes the leading edge. ST_HIGH holds the active level for one half period. On the tick it makes the trailing edge and goes back to ST_LOW, or to ST_TAIL after the last bit. ST_TAIL waits one more half period with select still held, then sets done and returns to ST_IDLE.

Top module: `spim_top`

## Requirements
- R1: After reset, the configuration register (word 0) reads 0x0002 and the status register (word 4) reads 0. Select is deasserted (high), the serial clock is low and the interrupt is low.
- R2: Each half period of the serial clock lasts max(P,1) system clock cycles, where P is configuration bits 7:0. A transfer of L bits makes exactly L leading edges.
- R3: Configuration bit 8 sets bit order. With 0 the bits leave from bit L-1 down to bit 0, and the first bit received lands in read-data bit L-1. With 1 the bits leave from bit 0 upward, and the first bit received lands in bit 0. The upper read-data bits are 0. Read data is word 3 and write data is word 2.
- R4: Configuration bit 11 sets clock phase. With 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge, so the first bit is valid before the first edge. With 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Configuration bit 10 sets clock polarity. The serial clock idles at the value of this bit, and the leading edge moves away from that level.
- R6: Configuration bit 9 sets select polarity: 0 means active-low, 1 means active-high. In automatic mode select is asserted for the whole of a transfer and released afterwards.
- R7: With configuration bit 12 set, select stays asserted after a transfer completes. Clearing bit 12 (or bit 13) releases it.
- R8: In the select register (word 5), bit 16 selects manual mode and bit 0 asserts select. Writing 0 returns to automatic mode with select released.
- R9: Writing the control register (word 1) with bit 0 set starts a transfer of L bits, where L is control bits 15:8. The value 0 or any value above 8 gives L = 8. The start is ignored while enable (configuration bit 13) is 0.
- R10: The status register clears to 0 on an accepted start. It reads 1 once the transfer has completed, and the received bits are then available in read data.
- R11: A start written while a transfer is in progress is ignored. Write data changed during a transfer does not alter the bits being sent.
- R12: The interrupt output is a level. It rises on completion when configuration bit 14 is set and clears on the next accepted start. It stays low when bit 14 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_cs | output | 1 | Slave select, polarity per configuration |
| spi_irq | output | 1 | Completion interrupt level |

## Verification
A corrupted bit counter or state register shows up at the pins within one transfer. The bench sees an extra or missing serial clock pulse, or a select line that lingers past ST_TAIL. A bad position index appears as swapped or misplaced bits in the word read back right after status goes to 1. A stale done or interrupt flag appears in the status read of the negedge right after a start, because both must drop in the cycle that leaves ST_IDLE. A divider error shows as a wrong high-phase length on the very first pulse.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_TXD  = 3'd2;
    localparam logic [2:0] A_RXD  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;
    localparam logic [2:0] A_SEL  = 3'd5;

    localparam int CB_LSB    = 8;
    localparam int CB_CSPOL  = 9;
    localparam int CB_CKPOL  = 10;
    localparam int CB_PHASE  = 11;
    localparam int CB_STREAM = 12;
    localparam int CB_EN     = 13;
    localparam int CB_IRQ    = 14;

    localparam logic [14:0] CFG_RESET = 15'h0002;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } spim_state_e;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    input  logic [DW-1:0] rx_data,
    input  logic          done,
    output logic [14:0]   cfg,
    output logic          sel_man,
    output logic          sel_lvl,
    output logic [DW-1:0] tx_data,
    output logic          start_req,
    output logic [7:0]    len_req,
    output logic [31:0]   rdata
);
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= CFG_RESET;
            sel_man <= 1'b0;
            sel_lvl <= 1'b0;
            tx_data <= '0;
        end else if (we) begin
            if (addr == A_CFG) cfg <= wdata[14:0];
            if (addr == A_TXD) tx_data <= wdata[DW-1:0];
            if (addr == A_SEL) begin
                sel_man <= wdata[16];
                sel_lvl <= wdata[0];
            end
        end
    end

    assign start_req = we && (addr == A_CTRL) && wdata[0];
    assign len_req   = wdata[15:8];

    always_comb begin
        case (addr)
            A_CFG:   rdata = {17'd0, cfg};
            A_TXD:   rdata = 32'(tx_data);
            A_RXD:   rdata = 32'(rx_data);
            A_STAT:  rdata = {31'd0, done};
            A_SEL:   rdata = {15'd0, sel_man, 15'd0, sel_lvl};
            default: rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/spim_timer.sv
module spim_timer #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] half,
    output logic          tick
);
    logic [PW-1:0] cnt;

    assign tick = run && (cnt == half - PW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + PW'(1);
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [7:0]    len_req,
    input  logic [DW-1:0] tx_data,
    input  logic          lsb_first,
    input  logic          phase,
    input  logic          stream_en,
    input  logic          enable,
    input  logic          irq_en,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sclk_int,
    output logic          mosi,
    output logic [DW-1:0] rx_data,
    output logic          done,
    output logic          irq,
    output logic          stream_hold
);
    localparam int CW = $clog2(DW + 1);
    localparam int IW = $clog2(DW);
    localparam logic [7:0]    DW_B = 8'(DW);
    localparam logic [CW-1:0] DW_C = CW'(DW);

    spim_state_e state, state_nxt;

    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] len_lat;
    logic [DW-1:0] tx_lat;
    logic [DW-1:0] rx_sh;
    logic [CW-1:0] len_eff;
    logic          start_go;
    logic          last_bit;
    logic [IW-1:0] idx_cur, idx_nxt, idx_first;

    function automatic logic [IW-1:0] bit_pos(input logic [CW-1:0] n,
                                              input logic [CW-1:0] len,
                                              input logic          lsb);
        logic [CW-1:0] p;
        p = lsb ? n : (len - CW'(1) - n);
        return p[IW-1:0];
    endfunction

    assign len_eff   = (len_req == 8'd0 || len_req > DW_B) ? DW_C : len_req[CW-1:0];
    assign start_go  = (state == ST_IDLE) && start_req && enable;
    assign last_bit  = (bit_cnt == len_lat - CW'(1));
    assign idx_cur   = bit_pos(bit_cnt, len_lat, lsb_first);
    assign idx_nxt   = bit_pos(bit_cnt + CW'(1), len_lat, lsb_first);
    assign idx_first = bit_pos('0, len_eff, lsb_first);
    assign busy      = (state != ST_IDLE);

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start_go) state_nxt = ST_LOW;
            ST_LOW:  if (tick)     state_nxt = ST_HIGH;
            ST_HIGH: if (tick)     state_nxt = last_bit ? ST_TAIL : ST_LOW;
            ST_TAIL: if (tick)     state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_int    <= 1'b0;
            mosi        <= 1'b0;
            bit_cnt     <= '0;
            len_lat     <= DW_C;
            tx_lat      <= '0;
            rx_sh       <= '0;
            rx_data     <= '0;
            done        <= 1'b0;
            irq         <= 1'b0;
            stream_hold <= 1'b0;
        end else begin
            if (!stream_en || !enable) stream_hold <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_go) begin
                        tx_lat  <= tx_data;
                        len_lat <= len_eff;
                        bit_cnt <= '0;
                        rx_sh   <= '0;
                        done    <= 1'b0;
                        irq     <= 1'b0;
                        mosi    <= phase ? 1'b0 : tx_data[idx_first];
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_int <= 1'b1;
                        if (!phase) rx_sh[idx_cur] <= miso;
                        else        mosi <= tx_lat[idx_cur];
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_int <= 1'b0;
                        bit_cnt  <= bit_cnt + CW'(1);
                        if (phase)          rx_sh[idx_cur] <= miso;
                        else if (!last_bit) mosi <= tx_lat[idx_nxt];
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        done        <= 1'b1;
                        rx_data     <= rx_sh;
                        irq         <= irq_en;
                        stream_hold <= stream_en && enable;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        spi_miso,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs,
    output logic        spi_irq
);
    localparam int PW = 8;

    logic [14:0]   cfg;
    logic          sel_man, sel_lvl;
    logic [DW-1:0] tx_data, rx_data;
    logic          start_req;
    logic [7:0]    len_req;
    logic          done, busy, tick, sclk_int, stream_hold;
    logic [PW-1:0] half;
    logic          cs_act;

    spim_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rx_data(rx_data), .done(done), .cfg(cfg), .sel_man(sel_man), .sel_lvl(sel_lvl),
        .tx_data(tx_data), .start_req(start_req), .len_req(len_req), .rdata(bus_rdata)
    );

    assign half = (cfg[PW-1:0] == '0) ? PW'(1) : cfg[PW-1:0];

    spim_timer #(.PW(PW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick)
    );

    spim_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .len_req(len_req),
        .tx_data(tx_data), .lsb_first(cfg[CB_LSB]), .phase(cfg[CB_PHASE]),
        .stream_en(cfg[CB_STREAM]), .enable(cfg[CB_EN]), .irq_en(cfg[CB_IRQ]),
        .tick(tick), .miso(spi_miso), .busy(busy), .sclk_int(sclk_int),
        .mosi(spi_mosi), .rx_data(rx_data), .done(done), .irq(spi_irq),
        .stream_hold(stream_hold)
    );

    assign cs_act   = sel_man ? sel_lvl : (busy || stream_hold);
    assign spi_cs   = cfg[CB_CSPOL] ? cs_act : ~cs_act;
    assign spi_sclk = sclk_int ^ cfg[CB_CKPOL];
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int DW = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    start_req,
    input logic                    done,
    input logic                    spi_irq,
    input logic                    spi_cs,
    input logic                    spi_sclk,
    input logic                    sel_man,
    input logic [14:0]             cfg,
    input logic [$clog2(DW+1)-1:0] len_lat,
    input logic [DW-1:0]           tx_lat
);
    // R5: clock rests at its polarity level whenever no transfer runs
    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_sclk == cfg[10]));

    // R10: accepted start leads to a busy engine with status cleared
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && cfg[13]) |=> (busy && !done));

    // R11: a start during a transfer leaves the latched transfer alone
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req) |=> ($stable(len_lat) && $stable(tx_lat)));

    // R12: interrupt only while the done status is set
    assert_irq_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_irq |-> done);

    // R6: automatic select asserted throughout a transfer
    assert_cs_auto_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_man) |-> (spi_cs == cfg[9]));

    // R9: no transfer starts while disabled
    assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg[13]) |=> !busy);
endmodule

bind spim_top spim_checker #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_req(start_req), .done(done),
    .spi_irq(spi_irq), .spi_cs(spi_cs), .spi_sclk(spi_sclk), .sel_man(sel_man),
    .cfg(cfg), .len_lat(u_eng.len_lat), .tx_lat(u_eng.tx_lat)
);

// File: tb/spim_tb.sv
module spim_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        spi_miso = 1'b0;
    logic        spi_sclk, spi_mosi, spi_cs, spi_irq;

    always #5 clk = ~clk;

    spim_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_miso(spi_miso),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_irq(spi_irq)
    );

    localparam int EN = 1 << 13, IRQE = 1 << 14, STRM = 1 << 12, PH = 1 << 11;
    localparam int CKP = 1 << 10, CSP = 1 << 9, LSB = 1 << 8;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // slave model state
    int       arm_id = 0, seen_id = 0;
    bit       b_inv = 0, b_ph = 0;
    bit [7:0] s_byte = 0, m_bits = 0;
    int       k = 0, lead = 0, run = 0, hi_len = 0;
    bit       prev = 0;

    // current-transfer expectations
    bit [7:0] cur_tx;
    int       cur_len, cur_half;
    bit       cur_lsb;

    always @(negedge clk) begin
        bit sc;
        sc = spi_sclk ^ b_inv;
        if (arm_id != seen_id) begin
            seen_id = arm_id; k = 0; lead = 0; m_bits = 0; run = 0; prev = sc;
            spi_miso = b_ph ? 1'b0 : s_byte[0];
        end else begin
            if (sc && !prev) begin
                lead++;
                if (!b_ph) begin if (k < 8) m_bits[k] = spi_mosi; end
                else if (k < 8) spi_miso = s_byte[k];
            end
            if (!sc && prev) begin
                hi_len = run;
                if (b_ph && k < 8) m_bits[k] = spi_mosi;
                k++;
                if (!b_ph && k < 8) spi_miso = s_byte[k];
            end
            run = sc ? run + 1 : 0;
            prev = sc;
        end
    end

    function automatic int eff_len(int f);
        return (f == 0 || f > 8) ? 8 : f;
    endfunction
    function automatic bit [7:0] exp_wire(bit [7:0] tx, int len, bit lsb);
        bit [7:0] r = 0;
        for (int i = 0; i < len; i++) r[i] = lsb ? tx[i] : tx[len-1-i];
        return r;
    endfunction
    function automatic bit [7:0] exp_rx(bit [7:0] sb, int len, bit lsb);
        bit [7:0] r = 0;
        for (int i = 0; i < len; i++) r[lsb ? i : len-1-i] = sb[i];
        return r;
    endfunction
    function automatic bit [7:0] mask(int len);
        return 8'((1 << len) - 1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd4, s);
            if (s[0]) return;
        end
    endtask

    task automatic launch(int cfg, bit [7:0] tx, int lenf);
        wr(3'd0, cfg);
        @(posedge clk);
        b_inv = cfg[10]; b_ph = cfg[11]; s_byte = 8'($urandom);
        arm_id++;
        cur_tx = tx; cur_len = eff_len(lenf); cur_lsb = cfg[8];
        cur_half = (cfg[7:0] == 0) ? 1 : cfg[7:0];
        wr(3'd2, {24'd0, tx});
        wr(3'd1, ((lenf & 32'hff) << 8) | 1);
    endtask

    task automatic finish_check(string tag);
        logic [31:0] v;
        wait_done();
        rd(3'd3, v);
        chk({tag, " rx data R3 R10"}, v, {24'd0, exp_rx(s_byte, cur_len, cur_lsb)});
        chk({tag, " mosi bits R3 R4"}, {24'd0, m_bits & mask(cur_len)},
            {24'd0, exp_wire(cur_tx, cur_len, cur_lsb)});
        chk({tag, " pulse count R2"}, lead, cur_len);
        chk({tag, " half period R2"}, hi_len, cur_half);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, v); chk("R1 cfg reset", v, 32'h2);
        rd(3'd4, v); chk("R1 status reset", v, 0);
        chk("R1 cs idle", spi_cs, 1);
        chk("R1 sclk idle", spi_sclk, 0);
        chk("R1 irq idle", spi_irq, 0);

        // directed: MSB first, phase 0, prescaler 2
        launch(EN | 2, 8'hA5, 8);
        rd(3'd4, v); chk("R10 status cleared on start", v, 0);
        chk("R6 cs asserted in transfer", spi_cs, 0);
        finish_check("R3 msb");
        chk("R6 cs released after", spi_cs, 1);
        // LSB first
        launch(EN | LSB | 3, 8'h3C, 8); finish_check("R3 lsb");
        // phase 1
        launch(EN | PH | 2, 8'h96, 8); finish_check("R4 phase1");
        // clock polarity
        wr(3'd0, EN | CKP | 2);
        @(negedge clk); chk("R5 sclk idle high", spi_sclk, 1);
        launch(EN | CKP | PH | 1, 8'h5A, 0); finish_check("R5 inverted");
        // select polarity
        wr(3'd0, EN | CSP | 2);
        @(negedge clk); chk("R6 cs active-high idle", spi_cs, 0);
        launch(EN | CSP | 2, 8'h81, 8);
        @(negedge clk); chk("R6 cs active-high busy", spi_cs, 1);
        finish_check("R6 cs sense");
        // prescaler zero
        launch(EN | 0, 8'hC3, 8); finish_check("R2 presc0");
        // short length and over-range length
        launch(EN | 2, 8'h0B, 4); finish_check("R9 len4");
        launch(EN | LSB | 1, 8'hE7, 12); finish_check("R9 len12");

        // R11: start while busy ignored
        launch(EN | 3, 8'hA5, 8);
        wr(3'd2, 32'h3C);
        wr(3'd1, 32'h0801);
        finish_check("R11 busy restart");
        repeat (100) @(negedge clk);
        chk("R11 no second transfer", lead, 8);
        rd(3'd4, v); chk("R11 status stays", v, 1);

        // R12 interrupt
        launch(EN | IRQE | 1, 8'h11, 8); finish_check("R12 irq xfer");
        @(negedge clk); chk("R12 irq raised", spi_irq, 1);
        launch(EN | 1, 8'h22, 8);
        @(negedge clk); chk("R12 irq cleared on start", spi_irq, 0);
        finish_check("R12 irq off xfer");
        @(negedge clk); chk("R12 irq stays low", spi_irq, 0);

        // R7 stream
        launch(EN | STRM | 1, 8'h44, 8); finish_check("R7 stream a");
        @(negedge clk); chk("R7 cs held", spi_cs, 0);
        launch(EN | STRM | 1, 8'h55, 8); finish_check("R7 stream b");
        @(negedge clk); chk("R7 cs still held", spi_cs, 0);
        wr(3'd0, EN | 1);
        @(negedge clk); chk("R7 cs released", spi_cs, 1);

        // R8 manual select
        wr(3'd5, 32'h10001);
        @(negedge clk); chk("R8 manual assert", spi_cs, 0);
        rd(3'd5, v); chk("R8 readback", v, 32'h10001);
        wr(3'd5, 32'h10000);
        @(negedge clk); chk("R8 manual release", spi_cs, 1);
        wr(3'd5, 32'h0);
        @(negedge clk); chk("R8 auto idle", spi_cs, 1);

        // R9 disabled start ignored
        launch(2, 8'h77, 8);
        repeat (60) @(negedge clk);
        chk("R9 disabled no pulses", lead, 0);
        chk("R9 disabled cs idle", spi_cs, 1);

        // random transfers
        for (int t = 0; t < 40; t++) begin
            int cfg;
            cfg = EN | int'($urandom_range(0, 3));
            if ($urandom_range(0, 1)) cfg |= LSB;
            if ($urandom_range(0, 1)) cfg |= PH;
            if ($urandom_range(0, 1)) cfg |= CKP;
            if ($urandom_range(0, 1)) cfg |= CSP;
            launch(cfg, 8'($urandom), int'($urandom_range(0, 10)));
            finish_check("R2 R3 R4 random");
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule